// File: doc/BRIEF.md
# Virtualized pattern table proxy

This block is the lookup and update front end of a spatial-pattern prefetcher. The prefetcher's full pattern history table lives in a reserved region of physical memory instead of in dedicated storage. A 21-bit trigger key is formed from 16 program-counter bits and a 5-bit block offset inside a 32-block spatial region. For each key the block answers with a 32-bit access pattern, one bit per block of the region, or with a miss. The table has 1024 sets of 11 ways. Each set is packed whole into one 64-byte memory block.

A small direct-mapped cache of whole sets sits on chip. A key whose set is cached is answered on the next cycle. A key whose set is not cached waits while the block does three things in order: it writes the evicted set back if that set is dirty, it reads the needed set's 512-bit block from the table base plus the set number times 64, and it unpacks the block. Pattern updates overwrite a matching entry or replace a way chosen round-robin, and they mark the cached set dirty. Only one memory transaction is open at a time, and new requests are held off until the current one completes.

Top module: `vpt_proxy`

## Requirements
- R1: The key splits as set number = key[9:0] and entry tag = key[20:10]. The on-chip slot is key[2:0], and each slot keeps the full 10-bit set number to tell sets apart.
- R2: A lookup whose set is cached raises rsp_valid_o for exactly one cycle, starting one cycle after acceptance, with rsp_hit_o=1 and the pattern of the lowest-numbered way whose tag matches.
- R3: A lookup that matches no way of its set returns rsp_hit_o=0 and rsp_pat_o=0.
- R4: In a set block, way w (0..10) keeps its tag at bits [43w+10:43w] and its pattern at bits [43w+42:43w+11]. Bits 511:473 carry no entry. A set that is written back and fetched again returns the same entries.
- R5: Every memory read or write of set s uses the address tbl_base_i + s*64.
- R6: A lookup or update whose slot holds a different set, or is empty, and is not dirty takes 3+L+S cycles from acceptance to result. L is the number of cycles from read acceptance to the read-data cycle, and S is the number of cycles the request waits for mem_ready_i.
- R7: An update whose tag matches a way overwrites only that way's pattern, marks the set dirty and produces no response pulse. When cached, it completes in one cycle.
- R8: An update whose tag matches no way writes tag and pattern into the way chosen by the slot's round-robin pointer. The pointer is 0 when the set is fetched, advances by one per such replacement, and wraps from way 10 back to way 0.
- R9: An update to a set that is not cached first fetches that set with one memory read and then applies the update.
- R10: Evicting a dirty set issues exactly one write of its packed block before the read of the new set, which adds 1+S cycles. Evicting a clean set issues no write.
- R11: Only one memory transaction is open at a time. req_ready_o stays low from acceptance until the request completes, and a memory request keeps its address and direction stable until mem_ready_i.
- R12: After reset req_ready_o=1, rsp_valid_o=0, mem_req_valid_o=0, and every slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_base_i | input | ADDR_W | Start address of the table region |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_upd_i | input | 1 | 1 = pattern update, 0 = lookup |
| req_key_i | input | 21 | Trigger key: tag in bits 20:10, set number in bits 9:0 |
| req_pat_i | input | 32 | Pattern to store on an update |
| rsp_valid_o | output | 1 | One-cycle lookup result pulse |
| rsp_hit_o | output | 1 | Tag found in the set |
| rsp_pat_o | output | 32 | Stored pattern, zero on a miss |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_we_o | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr_o | output | ADDR_W | Byte address of the set block |
| mem_wdata_o | output | 512 | Packed set for a write-back |
| mem_rsp_valid_i | input | 1 | Read data present |
| mem_rdata_i | input | 512 | Packed set returned by memory |

## Verification
A lookup to a cached set is due one cycle after acceptance. An uncached clean set is due 3+L+S cycles after acceptance, and a dirty eviction adds 1+S more. Updates finish in the same cycle counts, which the bench sees as req_ready_o rising again. The bench computes the due cycle from its own model of which set each slot holds and whether that set is dirty. It sets the memory latency L and the acceptance stall S per operation, counts falling edges after acceptance until the result appears, and compares that count, the pattern, and the number of memory writes and reads against the model. A monitor on every falling edge checks that each response pulse lasts one cycle. The memory model checks every address and every written-back block against a packed image of its reference table.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int IDX_W     = 21;
  localparam int SET_W     = 10;
  localparam int TAG_W     = IDX_W - SET_W;
  localparam int PAT_W     = 32;
  localparam int WAYS      = 11;
  localparam int ENT_W     = TAG_W + PAT_W;
  localparam int BLK_W     = 512;
  localparam int BLK_BYTES = BLK_W / 8;
  localparam int OFF_W     = $clog2(BLK_BYTES);
  localparam int WAY_W     = $clog2(WAYS);
  localparam int BIT_W     = $clog2(BLK_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_WB,
    ST_RD,
    ST_WAIT
  } state_e;
endpackage

// File: rtl/vpt_way_match.sv
module vpt_way_match
  import vpt_pkg::*;
(
  input  logic [BLK_W-1:0] blk_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o,
  output logic [PAT_W-1:0] pat_o
);
  logic [WAYS-1:0]  eq;
  logic [PAT_W-1:0] way_pat [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign eq[w]      = (blk_i[w*ENT_W +: TAG_W] == tag_i);
    assign way_pat[w] = blk_i[w*ENT_W + TAG_W +: PAT_W];
  end

  // lowest matching way wins
  always_comb begin
    hit_o = |eq;
    way_o = '0;
    pat_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) begin
        way_o = WAY_W'(w);
        pat_o = way_pat[w];
      end
    end
  end
endmodule

// File: rtl/vpt_line_store.sv
module vpt_line_store
  import vpt_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW   = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LW-1:0]    slot_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [SET_W-1:0] set_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [WAY_W-1:0] rr_o,
  input  logic             fill_en_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [BLK_W-1:0] fill_blk_i,
  input  logic             upd_en_i,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic [PAT_W-1:0] upd_pat_i,
  input  logic             upd_adv_i
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [SET_W-1:0] set_q [LINES];
  logic [WAY_W-1:0] rr_q  [LINES];
  logic [BLK_W-1:0] blk_q [LINES];
  logic [BIT_W-1:0] ent_base;

  assign ent_base = BIT_W'(upd_way_i) * BIT_W'(ENT_W);

  assign valid_o = valid_q[slot_i];
  assign dirty_o = dirty_q[slot_i];
  assign set_o   = set_q[slot_i];
  assign rr_o    = rr_q[slot_i];
  assign blk_o   = blk_q[slot_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        set_q[i] <= '0;
        rr_q[i]  <= '0;
      end
    end else if (fill_en_i) begin
      valid_q[slot_i] <= 1'b1;
      dirty_q[slot_i] <= 1'b0;
      set_q[slot_i]   <= fill_set_i;
      rr_q[slot_i]    <= '0;
    end else if (upd_en_i) begin
      dirty_q[slot_i] <= 1'b1;
      if (upd_adv_i) begin
        rr_q[slot_i] <= (rr_q[slot_i] == WAY_W'(WAYS - 1)) ? '0 : rr_q[slot_i] + 1'b1;
      end
    end
  end

  // payload carries no reset
  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      blk_q[slot_i] <= fill_blk_i;
    end else if (upd_en_i) begin
      blk_q[slot_i][ent_base +: TAG_W]         <= upd_tag_i;
      blk_q[slot_i][ent_base + TAG_W +: PAT_W] <= upd_pat_i;
    end
  end

  // R9
  upd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |-> valid_o);

  // R8
  rr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_adv_i && rr_o == WAY_W'(WAYS - 1)) |=> (rr_o == '0));

  // R10
  fill_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !upd_en_i) |=> (valid_o && !dirty_o));
endmodule

// File: rtl/vpt_proxy.sv
module vpt_proxy
  import vpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 8,
  localparam int LW    = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_upd_i,
  input  logic [IDX_W-1:0]  req_key_i,
  input  logic [PAT_W-1:0]  req_pat_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [PAT_W-1:0]  rsp_pat_o,
  output logic              mem_req_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BLK_W-1:0]  mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [BLK_W-1:0]  mem_rdata_i
);
  state_e state_q, state_d;

  logic             upd_q;
  logic [IDX_W-1:0] key_q;
  logic [PAT_W-1:0] pat_q;
  logic [SET_W-1:0] key_set;
  logic [TAG_W-1:0] key_tag;
  logic [LW-1:0]    key_slot;

  logic             ln_valid, ln_dirty, ln_hit;
  logic [SET_W-1:0] ln_set;
  logic [BLK_W-1:0] ln_blk;
  logic [WAY_W-1:0] ln_rr;

  logic             m_hit;
  logic [WAY_W-1:0] m_way;
  logic [PAT_W-1:0] m_pat;

  logic             accept, fill_en, upd_en, upd_adv, rsp_fire;
  logic [WAY_W-1:0] upd_way;
  logic [SET_W-1:0] mem_set;

  logic             rsp_valid_q, rsp_hit_q;
  logic [PAT_W-1:0] rsp_pat_q;

  assign key_set  = key_q[SET_W-1:0];
  assign key_tag  = key_q[IDX_W-1:SET_W];
  assign key_slot = key_set[LW-1:0];

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign ln_hit      = ln_valid && (ln_set == key_set);

  vpt_line_store #(.LINES(LINES)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (key_slot),
    .valid_o    (ln_valid),
    .dirty_o    (ln_dirty),
    .set_o      (ln_set),
    .blk_o      (ln_blk),
    .rr_o       (ln_rr),
    .fill_en_i  (fill_en),
    .fill_set_i (key_set),
    .fill_blk_i (mem_rdata_i),
    .upd_en_i   (upd_en),
    .upd_way_i  (upd_way),
    .upd_tag_i  (key_tag),
    .upd_pat_i  (pat_q),
    .upd_adv_i  (upd_adv)
  );

  vpt_way_match u_match (
    .blk_i (ln_blk),
    .tag_i (key_tag),
    .hit_o (m_hit),
    .way_o (m_way),
    .pat_o (m_pat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      key_q <= '0;
      pat_q <= '0;
    end else if (accept) begin
      upd_q <= req_upd_i;
      key_q <= req_key_i;
      pat_q <= req_pat_i;
    end
  end

  always_comb begin
    state_d         = state_q;
    fill_en         = 1'b0;
    upd_en          = 1'b0;
    upd_adv         = 1'b0;
    upd_way         = m_way;
    rsp_fire        = 1'b0;
    mem_req_valid_o = 1'b0;
    mem_we_o        = 1'b0;
    mem_set         = key_set;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_CHK;
      ST_CHK: begin
        if (ln_hit) begin
          if (upd_q) begin
            upd_en = 1'b1;
            if (!m_hit) begin
              upd_way = ln_rr;
              upd_adv = 1'b1;
            end
          end else begin
            rsp_fire = 1'b1;
          end
          state_d = ST_IDLE;
        end else if (ln_valid && ln_dirty) begin
          state_d = ST_WB;
        end else begin
          state_d = ST_RD;
        end
      end
      ST_WB: begin
        mem_req_valid_o = 1'b1;
        mem_we_o        = 1'b1;
        mem_set         = ln_set;
        if (mem_ready_i) state_d = ST_RD;
      end
      ST_RD: begin
        mem_req_valid_o = 1'b1;
        if (mem_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid_i) begin
          fill_en = 1'b1;
          state_d = ST_CHK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_addr_o  = tbl_base_i + (ADDR_W'(mem_set) << OFF_W);
  assign mem_wdata_o = ln_blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_pat_q   <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_fire;
      if (rsp_fire) begin
        rsp_hit_q <= m_hit;
        rsp_pat_q <= m_hit ? m_pat : '0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_pat_o   = rsp_pat_q;

  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_ready_i) |=>
      (mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R11
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  // R2
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R3
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_pat_o == '0));

  // R10
  wb_then_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_we_o && mem_ready_i) |=> (mem_req_valid_o && !mem_we_o));
endmodule

// File: tb/vpt_proxy_test.sv
module vpt_proxy_test;
  localparam int AW    = 32;
  localparam int NL    = 8;
  localparam int NSETS = 1024;
  localparam int NW    = 11;

  logic         clk, rst_n;
  logic [AW-1:0] base;
  logic         req_valid, req_ready, req_upd;
  logic [20:0]  req_key;
  logic [31:0]  req_pat;
  logic         rsp_valid, rsp_hit;
  logic [31:0]  rsp_pat;
  logic         mem_req_valid, mem_ready, mem_we, mem_rsp_valid;
  logic [AW-1:0] mem_addr;
  logic [511:0] mem_wdata, mem_rdata;

  vpt_proxy #(.ADDR_W(AW), .LINES(NL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tbl_base_i(base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_upd_i(req_upd),
    .req_key_i(req_key), .req_pat_i(req_pat),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_pat_o(rsp_pat),
    .mem_req_valid_o(mem_req_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rdata_i(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [10:0] ref_tag [NSETS][NW];
  logic [31:0] ref_pat [NSETS][NW];
  logic [10:0] mem_tag [NSETS][NW];
  logic [31:0] mem_pat [NSETS][NW];
  int slot_set [NL];
  bit slot_dirty [NL];
  int slot_rr [NL];

  int mem_lat = 1, acc_stall = 0, stall_cnt = 0, rd_cnt = 0, rd_set = 0;
  int cur_set = 0, exp_wb_set = -1;
  int wr_seen = 0, rd_seen = 0, rsp_count = 0;
  bit rsp_prev = 0;

  function automatic logic [10:0] init_tag(int s, int w);
    if (s == 777) return 11'h123;
    return 11'((s + w * 97) % 2048);
  endfunction

  function automatic logic [31:0] init_pat(int s, int w);
    return 32'hA5A5_0000 ^ (32'(s) << 8) ^ 32'(w * 17 + 1);
  endfunction

  function automatic logic [511:0] pack_ref(int s);
    logic [511:0] b = '0;
    for (int w = 0; w < NW; w++) begin
      b[w*43 +: 11]    = ref_tag[s][w];
      b[w*43+11 +: 32] = ref_pat[s][w];
    end
    return b;
  endfunction

  function automatic logic [511:0] pack_mem(int s);
    logic [511:0] b = '0;
    for (int w = 0; w < NW; w++) begin
      b[w*43 +: 11]    = mem_tag[s][w];
      b[w*43+11 +: 32] = mem_pat[s][w];
    end
    return b;
  endfunction

  task automatic chk(string rq, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // memory model: variable acceptance stall and read latency
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rdata     = pack_mem(rd_set);
      end
    end
    mem_ready = 1'b0;
    if (rst_n && mem_req_valid) begin
      if (stall_cnt < acc_stall) begin
        stall_cnt++;
      end else begin
        stall_cnt = 0;
        mem_ready = 1'b1;
        if (mem_we) begin
          wr_seen++;
          if (exp_wb_set >= 0) begin
            chk("R5", "write-back address", mem_addr, base + (32'(exp_wb_set) << 6));
            chk("R4", "write-back block", mem_wdata, pack_ref(exp_wb_set));
            for (int w = 0; w < NW; w++) begin
              mem_tag[exp_wb_set][w] = mem_wdata[w*43 +: 11];
              mem_pat[exp_wb_set][w] = mem_wdata[w*43+11 +: 32];
            end
          end else begin
            chk("R10", "unexpected write-back", 1, 0);
          end
        end else begin
          rd_seen++;
          chk("R5", "read address", mem_addr, base + (32'(cur_set) << 6));
          rd_set = cur_set;
          rd_cnt = mem_lat;
        end
      end
    end
  end

  // response pulse monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        rsp_count++;
        chk("R2", "response pulse longer than one cycle", rsp_prev, 0);
      end
      rsp_prev = rsp_valid;
    end
  end

  task automatic do_op(string rq, bit upd, int s, logic [10:0] t, logic [31:0] p, int lat, int stall);
    int  slot   = s % NL;
    bit  cached = (slot_set[slot] == s);
    bit  wb     = !cached && slot_set[slot] >= 0 && slot_dirty[slot];
    int  exp_n, n, w0, r0, c0, mw;
    mem_lat    = lat;
    acc_stall  = stall;
    cur_set    = s;
    exp_wb_set = wb ? slot_set[slot] : -1;
    exp_n = cached ? 1 : (wb ? 4 + lat + 2 * stall : 3 + lat + stall);
    mw = -1;
    for (int w = NW - 1; w >= 0; w--) if (ref_tag[s][w] == t) mw = w;
    n = 0;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    w0 = wr_seen; r0 = rd_seen; c0 = rsp_count;
    req_valid = 1'b1;
    req_upd   = upd;
    req_key   = {t, 10'(s)};
    req_pat   = p;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    if (!upd) begin
      while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
      chk(rq, "lookup hit flag", rsp_hit, mw >= 0);
      chk(rq, "lookup pattern", rsp_pat, (mw >= 0) ? ref_pat[s][mw] : 32'h0);
    end else begin
      while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    end
    #1;
    if (cached) chk(upd ? "R7" : "R2", "cycles to result (cached)", n, exp_n);
    else if (stall > 0) chk("R11", "cycles to result (stalled memory)", n, exp_n);
    else if (wb) chk("R10", "cycles to result (dirty eviction)", n, exp_n);
    else chk("R6", "cycles to result (set fetch)", n, exp_n);
    chk("R10", "write-backs issued", wr_seen - w0, wb ? 1 : 0);
    chk("R9", "reads issued", rd_seen - r0, cached ? 0 : 1);
    chk("R7", "response pulses", rsp_count - c0, upd ? 0 : 1);
    if (!cached) begin
      slot_set[slot]   = s;
      slot_dirty[slot] = 0;
      slot_rr[slot]    = 0;
    end
    if (upd) begin
      if (mw >= 0) ref_pat[s][mw] = p;
      else begin
        ref_tag[s][slot_rr[slot]] = t;
        ref_pat[s][slot_rr[slot]] = p;
        slot_rr[slot] = (slot_rr[slot] + 1) % NW;
      end
      slot_dirty[slot] = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NW; w++) begin
        ref_tag[s][w] = init_tag(s, w);
        ref_pat[s][w] = init_pat(s, w);
        mem_tag[s][w] = init_tag(s, w);
        mem_pat[s][w] = init_pat(s, w);
      end
    for (int i = 0; i < NL; i++) begin
      slot_set[i] = -1; slot_dirty[i] = 0; slot_rr[i] = 0;
    end
    base = 32'h8000_0000;
    req_valid = 0; req_upd = 0; req_key = '0; req_pat = '0;
    mem_ready = 0; mem_rsp_valid = 0; mem_rdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "ready in reset", req_ready, 1);
    chk("R12", "response in reset", rsp_valid, 0);
    chk("R12", "memory request in reset", mem_req_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "memory request after reset", mem_req_valid, 0);

    do_op("R1", 0, 5, init_tag(5, 3), '0, 2, 0);
    do_op("R2", 0, 5, init_tag(5, 7), '0, 1, 0);
    do_op("R3", 0, 5, 11'd10, '0, 1, 0);
    do_op("R7", 1, 5, init_tag(5, 3), 32'hDEAD_BEEF, 1, 0);
    do_op("R7", 0, 5, init_tag(5, 3), '0, 1, 0);
    // R8 twelve replacements wrap the pointer
    for (int i = 0; i < 12; i++)
      do_op("R8", 1, 5, 11'h400 + 11'(i), 32'h1111_1111 * 32'(i + 1), 1, 0);
    do_op("R8", 0, 5, 11'h400, '0, 1, 0);
    do_op("R8", 0, 5, 11'h40B, '0, 1, 0);
    do_op("R8", 0, 5, 11'h401, '0, 1, 0);
    do_op("R8", 0, 5, init_tag(5, 3), '0, 1, 0);
    // R10 dirty eviction with stalled memory
    do_op("R10", 0, 13, init_tag(13, 0), '0, 3, 2);
    // R4 round trip through memory
    do_op("R4", 0, 5, 11'h40B, '0, 1, 0);
    do_op("R4", 0, 5, 11'h405, '0, 5, 0);
    // R9 update to an uncached set
    do_op("R9", 1, 200, 11'h7FF, 32'hFFFF_FFFF, 4, 0);
    do_op("R9", 0, 200, 11'h7FF, '0, 1, 0);
    do_op("R2", 0, 777, 11'h123, '0, 2, 1);
    do_op("R1", 0, 1023, init_tag(1023, 10), '0, 1, 0);
    do_op("R1", 0, 0, init_tag(0, 0), '0, 2, 0);
    do_op("R9", 0, 200, 11'h7FF, '0, 1, 0);
    do_op("R3", 0, 1023, 11'h7FE, '0, 1, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule